// File: doc/BRIEF.md
# Serial Timestamp and Frame-Sync Word Capture

This block sits beside the compressed-audio serial input and watches the same bit line. Two side-band strobes share that line. A rising edge on the timing strobe starts capture of a 34-bit timing word. A rising edge on the sync strobe starts capture of a 12-bit frame synchronization word. In both cases the first bit of the word is on the serial line in the same accepted cycle as the strobe's rise, and bits arrive most significant first. A timing word is classified by its first bit as either a presentation timestamp or a system clock reference.

Each finished word appears on a parallel output together with a type tag and a one-cycle valid pulse. While a capture consumes bits, an exclude output tells the neighbouring data path to drop those bits. Bits, and strobe edges, are only seen on clock edges where the shared input-accept condition is high. Recovering a clock from the timestamps and decoding frames are done elsewhere.

Top module: `tsc_capture`

## Requirements
- R1: While reset is low, and in the first cycle after it, `word_valid` and `data_exclude` are 0 when no strobe is high.
- R2: A rise of `tmode` seen on an accepted edge captures that bit and the next 33 accepted bits of `ser_bit`, MSB first, into `word_data[33:0]`.
- R3: The first bit of a timing word sets `word_type`: 0 gives 2'b00 (presentation timestamp), and 1 gives 2'b01 (system clock reference).
- R4: A rise of `hsync` seen on an accepted edge captures 12 accepted bits, MSB first, into `word_data[11:0]`, with `word_data[33:12]` zero and `word_type` = 2'b10.
- R5: `word_valid` is high for exactly one cycle, the cycle after the edge that takes the last bit of a word.
- R6: `data_exclude` is high in exactly those cycles in which a bit is taken by a capture, and low for ordinary data.
- R7: Bits and strobe levels are counted only on edges where `bit_accept` is high. A strobe that goes high and low again while `bit_accept` is low starts nothing.
- R8: Strobe rises during an active capture are ignored, and the word in progress completes unchanged.
- R9: If both strobes rise on the same accepted edge, a timing word is captured.
- R10: Reset abandons a partial capture, and no valid pulse follows for it.
- R11: With `hsync` held low, serial traffic never yields a sync capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_accept | input | 1 | Shared input-accept condition: a serial bit is present this edge |
| ser_bit | input | 1 | Serial data bit |
| tmode | input | 1 | Timing-word strobe |
| hsync | input | 1 | Hardware frame-sync strobe |
| data_exclude | output | 1 | Current bit belongs to a capture; data path must drop it |
| word_valid | output | 1 | One-cycle pulse: captured word available |
| word_type | output | 2 | 00 timestamp, 01 clock reference, 10 sync word |
| word_data | output | 34 | Captured word, right-aligned |

## Verification
The bench builds the block with its default widths: 34 bits for a timing word and 12 for a sync word. These sizes reach the boundary where the first bit decides the timing-word type, and they make the sync word narrower than the output bus, so the zero-fill of the upper bits can be observed. Words are also sent with stalls of `bit_accept` inserted between bits, which exercises the gated bit counting across both word lengths.

// File: rtl/tsc_pkg.sv
// Package: shared word-type encoding for the capture block.
package tsc_pkg;
    typedef enum logic [1:0] {
        WK_PTS  = 2'b00,
        WK_SCR  = 2'b01,
        WK_SYNC = 2'b10
    } word_kind_e;
endpackage

// File: rtl/tsc_edge.sv
// Strobe rise detector working in the accepted-bit domain.
// Assumes the strobe is meaningful only on edges where accept is high;
// the remembered level updates only on those edges.
module tsc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    // Remember the strobe level seen on the last accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (accept)
            prev_q <= strobe;
    end

    assign rise = accept & strobe & ~prev_q;
endmodule

// File: rtl/tsc_shift.sv
// Shift-and-count engine. It starts on a start request, takes the
// current bit as the MSB, and counts the remaining accepted bits.
// Assumes that start requests are already qualified by accept.
module tsc_shift
    import tsc_pkg::*;
#(
    parameter int TS_BITS   = 34,
    parameter int SYNC_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               ser_bit,
    input  logic               start_ts,
    input  logic               start_sync,
    output logic               consume,
    output logic               out_valid,
    output word_kind_e         out_kind,
    output logic [TS_BITS-1:0] out_data
);
    localparam int CW = $clog2(TS_BITS + 1);

    logic               busy_q;
    logic [CW-1:0]      left_q;
    logic [TS_BITS-1:0] sh_q;
    logic               start;

    assign start   = ~busy_q & (start_ts | start_sync);
    assign consume = start | (busy_q & accept);

    // Start, shift and finish a capture; raise valid after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            left_q    <= '0;
            sh_q      <= '0;
            out_valid <= 1'b0;
            out_kind  <= WK_PTS;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                sh_q   <= {{(TS_BITS-1){1'b0}}, ser_bit};
                if (start_ts) begin
                    left_q   <= CW'(TS_BITS - 1);
                    out_kind <= ser_bit ? WK_SCR : WK_PTS;
                end else begin
                    left_q   <= CW'(SYNC_BITS - 1);
                    out_kind <= WK_SYNC;
                end
            end else if (busy_q && accept) begin
                sh_q   <= {sh_q[TS_BITS-2:0], ser_bit};
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    busy_q    <= 1'b0;
                    out_valid <= 1'b1;
                end
            end
        end
    end

    assign out_data = sh_q;
endmodule

// File: rtl/tsc_capture.sv
// Top: timestamp and frame-sync word capture on a shared serial line.
// It detects the rise of each strobe on accepted edges, gives a timing
// word priority over a sync word, and drives the data-exclude flag.
module tsc_capture
    import tsc_pkg::*;
#(
    parameter int TS_BITS   = 34,
    parameter int SYNC_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_accept,
    input  logic               ser_bit,
    input  logic               tmode,
    input  logic               hsync,
    output logic               data_exclude,
    output logic               word_valid,
    output logic [1:0]         word_type,
    output logic [TS_BITS-1:0] word_data
);
    logic       ts_rise, sy_rise;
    word_kind_e kind;

    tsc_edge u_ts_edge (
        .clk(clk), .rst_n(rst_n), .accept(bit_accept),
        .strobe(tmode), .rise(ts_rise)
    );

    tsc_edge u_sy_edge (
        .clk(clk), .rst_n(rst_n), .accept(bit_accept),
        .strobe(hsync), .rise(sy_rise)
    );

    tsc_shift #(.TS_BITS(TS_BITS), .SYNC_BITS(SYNC_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .accept(bit_accept), .ser_bit(ser_bit),
        .start_ts(ts_rise), .start_sync(sy_rise & ~ts_rise),
        .consume(data_exclude), .out_valid(word_valid),
        .out_kind(kind), .out_data(word_data)
    );

    assign word_type = kind;
endmodule

// File: rtl/tsc_checker.sv
// Checker for tsc_capture: properties on the output ports over time.
module tsc_checker #(
    parameter int W = 34,
    parameter int S = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_accept,
    input logic         data_exclude,
    input logic         word_valid,
    input logic [1:0]   word_type,
    input logic [W-1:0] word_data
);
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    // R5
    valid_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(data_exclude));
    // R7
    exclude_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_exclude |-> bit_accept);
    // R3
    pts_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_type == 2'b00) |-> !word_data[W-1]);
    // R3
    scr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_type == 2'b01) |-> word_data[W-1]);
    // R4
    sync_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_type == 2'b10) |-> (word_data >> S) == '0);
endmodule

bind tsc_capture tsc_checker #(.W(TS_BITS), .S(SYNC_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_accept(bit_accept),
    .data_exclude(data_exclude), .word_valid(word_valid),
    .word_type(word_type), .word_data(word_data)
);

// File: tb/sim_tsc_capture.sv
module sim_tsc_capture;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_accept = 1'b0;
    logic        ser_bit = 1'b0;
    logic        tmode = 1'b0;
    logic        hsync = 1'b0;
    logic        data_exclude, word_valid;
    logic [1:0]  word_type;
    logic [33:0] word_data;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_capture u0 (
        .clk(clk), .rst_n(rst_n), .bit_accept(bit_accept), .ser_bit(ser_bit),
        .tmode(tmode), .hsync(hsync), .data_exclude(data_exclude),
        .word_valid(word_valid), .word_type(word_type), .word_data(word_data)
    );

    // Vector: [35] sync word, [34] stalls between bits, [33:0] value
    localparam logic [35:0] VEC [6] = '{
        {1'b0, 1'b0, 34'h0_1234_5678},
        {1'b0, 1'b0, 34'h3_ABCD_0123},
        {1'b1, 1'b0, 34'h0_0000_0FFF},
        {1'b1, 1'b1, 34'h0_0000_0A5C},
        {1'b0, 1'b1, 34'h1_0F0F_F0F0},
        {1'b0, 1'b1, 34'h2_0000_0001}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send one word; both = raise hsync with tmode; poke = hsync rise mid-word.
    task automatic send(input bit is_sync, input logic [33:0] val, input bit stall,
                        input bit both, input bit poke);
        int len = is_sync ? 12 : 34;
        logic [1:0] ety = is_sync ? 2'b10 : (val[33] ? 2'b01 : 2'b00);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            if (stall && (i % 3 == 1)) begin
                bit_accept = 1'b0; ser_bit = ~ser_bit;
                #1 chk(data_exclude == 1'b0, "R7 stall exclude", data_exclude, 0);
                @(negedge clk);
            end
            bit_accept = 1'b1; ser_bit = val[i];
            if (is_sync) hsync = 1'b1; else tmode = 1'b1;
            if (both) hsync = 1'b1;
            if (poke) hsync = (i < len - 5);
            #1 chk(data_exclude == 1'b1, "R6 exclude during capture", data_exclude, 1);
        end
        @(negedge clk);
        tmode = 1'b0; hsync = 1'b0; ser_bit = 1'b0;
        #1;
        chk(word_valid == 1'b1, "R5 valid after last bit", word_valid, 1);
        chk(word_data == val, is_sync ? "R4 sync data" : "R2 timing data", word_data, val);
        chk(word_type == ety, is_sync ? "R4 sync type" : "R3 timing type", word_type, ety);
        chk(data_exclude == 1'b0, "R6 idle exclude", data_exclude, 0);
        @(negedge clk);
        #1 chk(word_valid == 1'b0, "R5 single pulse", word_valid, 0);
    endtask

    // Idle accepted data cycles; no capture may appear (R11 and others).
    task automatic idle(input int n, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_accept = 1'b1; ser_bit = k[0] ^ k[2];
            #1 if (word_valid || data_exclude) seen = 1'b1;
        end
        chk(!seen, req, seen, 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        bit_accept = 1'b1;
        #1 chk(word_valid == 0 && data_exclude == 0, "R1 in reset",
               {word_valid, data_exclude}, 0);
        @(negedge clk); rst_n = 1'b1;
        #1 chk(word_valid == 0 && data_exclude == 0, "R1 after reset",
               {word_valid, data_exclude}, 0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            send(VEC[v][35], VEC[v][33:0], VEC[v][34], 1'b0, 1'b0);
            idle(2, "R6 gap between words");
        end

        // R9: both strobes rise together
        send(1'b0, 34'h0_5555_AAAA, 1'b0, 1'b1, 1'b0);
        idle(2, "R9 gap");

        // R8: hsync rises mid timing word and is ignored
        send(1'b0, 34'h2_DEAD_BEEF, 1'b0, 1'b0, 1'b1);
        idle(40, "R8 no late sync capture");

        // R7: strobe pulse while accept is low starts nothing
        @(negedge clk); bit_accept = 1'b0; tmode = 1'b1;
        @(negedge clk); tmode = 1'b0;
        idle(40, "R7 unaccepted strobe");

        // R10: reset in the middle of a capture
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); bit_accept = 1'b1; tmode = 1'b1; ser_bit = i[0];
        end
        @(negedge clk); rst_n = 1'b0; tmode = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(40, "R10 partial word dropped");
        send(1'b1, 34'h0_0000_0123, 1'b0, 1'b0, 1'b0);

        // R11: long data stream with hsync low
        idle(200, "R11 no sync capture");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule